// File: doc/BRIEF.md
# Addressable 9-bit UART Receiver

This block receives asynchronous serial characters on a multi-drop line such as an RS-485 bus. A baud tick at sixteen times the bit rate drives an oversampling receiver. The receiver confirms each start bit at mid-bit and takes every data bit by a majority vote of three samples around the bit centre. Characters are 8 or 9 bits long and arrive least significant bit first. Each completed character moves into a one-entry receive buffer. Software reads that buffer through a read strobe.

Status outputs report the ninth bit, a framing error and a sticky overrun error. A ready flag, gated by an interrupt enable, drives an interrupt line. In address-detect mode only characters with the ninth bit set reach the buffer. Every other character is dropped without notice, so a node can ignore bus traffic until it sees its own address. Once it has been addressed, software clears the address-detect enable and every character is accepted. A polarity control inverts the line for links whose idle level is low.

Top module: `addr_uart_rx`

## Requirements
- R1: The receiver accepts characters only while `port_en_i` and `rx_en_i` are both 1 and `sync_mode_i` is 0. At any other time, frames on the line leave `ready_o` at 0.
- R2: In 8-bit mode (`nine_bit_i`=0) the first data bit on the line becomes bit 0 of `data_o`, and `bit9_o` reads 0.
- R3: In 9-bit mode the bit that follows the eight data bits is reported on `bit9_o` together with its character.
- R4: With `invert_i`=1 the line idles low and every bit, start and stop bits included, is received inverted.
- R5: `ready_o` rises when a character is loaded into the buffer. A one-cycle `rd_data_i` pulse clears it. `irq_o` is 1 exactly when `ready_o` and `irq_en_i` are both 1. After reset `ready_o`, `overrun_o`, `irq_o` and `data_o` are 0.
- R6: A stop bit sampled low sets `frame_err_o` for that character. The flag is rewritten each time a new character is loaded.
- R7: With `addr_det_i`=1 in 9-bit mode, a character whose ninth bit is 0 is discarded and leaves `ready_o` at 0. A character whose ninth bit is 1 is loaded.
- R8: With `addr_det_i`=0, characters are loaded whatever their ninth bit.
- R9: If a character completes while `ready_o` is 1, `overrun_o` sets, the new character is dropped and `data_o` keeps the unread character.
- R10: `overrun_o` stays 1 until `rx_en_i` is 0, and then it clears. While it is set, no new character is received.
- R11: A low pulse on the line that is high again at the mid-point of the start bit does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Oversampling tick, 16 per bit period |
| rx_i | input | 1 | Serial line input |
| port_en_i | input | 1 | Serial port enable |
| rx_en_i | input | 1 | Receive enable; low clears overrun |
| sync_mode_i | input | 1 | Synchronous mode select; must be 0 to receive |
| nine_bit_i | input | 1 | 1 selects 9-bit characters |
| addr_det_i | input | 1 | Address-detect filtering enable |
| invert_i | input | 1 | Invert line polarity |
| irq_en_i | input | 1 | Interrupt enable |
| rd_data_i | input | 1 | Read strobe; pops the buffer |
| data_o | output | 8 | Buffered data byte |
| bit9_o | output | 1 | Buffered ninth bit |
| frame_err_o | output | 1 | Framing error of the buffered character |
| overrun_o | output | 1 | Sticky overrun error |
| ready_o | output | 1 | Buffer holds an unread character |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong sample phase or a wrong bit count shows up as a shifted or corrupted `data_o` on the next character the scoreboard pops, one frame after the fault. A buffer-full state that is wrong appears either as a spurious `overrun_o` within one frame or as a missing `ready_o` where one is expected. A filter or halt state that is stuck is caught at the end of the next frame, when `ready_o` stays 0 where it should rise or rises where it should stay 0. If the overrun flag is not sticky, the status check made while receive is still enabled shows it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned OVS      = 16;
  localparam int unsigned CNT_W    = $clog2(OVS);
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned MID_SMP  = OVS / 2;
  localparam int unsigned IDX_W    = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              bit9;
    logic              ferr;
  } rx_char_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rx_front.sv
module rx_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic invert_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  assign line_o = sync_q[SYNC_STAGES-1] ^ invert_i;
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import uart_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     line_i,
  input  logic     en_i,
  input  logic     halt_i,
  input  logic     nine_bit_i,
  output logic     done_o,
  output rx_char_t char_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [2:0]        smp_q;
  logic [DATA_W-1:0] data_q;
  logic              bit9_q;
  logic              vote;
  logic [IDX_W-1:0]  last_idx;

  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(MID_SMP - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(MID_SMP);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(MID_SMP + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OVS - 1);

  assign last_idx = nine_bit_i ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  // stop bit is decided at the third sample, using the live line level
  assign vote = (cnt_q == SMP_C) ? maj3(smp_q[0], smp_q[1], line_i)
                                 : maj3(smp_q[0], smp_q[1], smp_q[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      data_q  <= '0;
      bit9_q  <= 1'b0;
      done_o  <= 1'b0;
      char_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= S_IDLE;
      end else if (tick_i) begin
        if (state_q != S_IDLE) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == SMP_A) smp_q[0] <= line_i;
        if (cnt_q == SMP_B) smp_q[1] <= line_i;
        if (cnt_q == SMP_C) smp_q[2] <= line_i;
        unique case (state_q)
          S_IDLE: begin
            if (!line_i && !halt_i) begin
              state_q <= S_START;
              cnt_q   <= CNT_W'(1);
            end
          end
          S_START: begin
            if (cnt_q == SMP_B && line_i) state_q <= S_IDLE;
            else if (cnt_q == CNT_END) begin
              state_q <= S_DATA;
              idx_q   <= '0;
              bit9_q  <= 1'b0;
            end
          end
          S_DATA: begin
            if (cnt_q == CNT_END) begin
              if (idx_q < IDX_W'(DATA_W)) data_q[idx_q[IDX_W-2:0]] <= vote;
              else                        bit9_q <= vote;
              if (idx_q == last_idx) state_q <= S_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt_q == SMP_C) begin
              state_q     <= S_IDLE;
              done_o      <= 1'b1;
              char_o.data <= data_q;
              char_o.bit9 <= bit9_q;
              char_o.ferr <= ~vote;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == S_IDLE); // R1

  AST_HALT_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && halt_i) |=> state_q == S_IDLE); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import uart_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     done_i,
  input  rx_char_t char_i,
  input  logic     nine_bit_i,
  input  logic     addr_det_i,
  input  logic     rx_en_i,
  input  logic     rd_i,
  output rx_char_t buf_o,
  output logic     full_o,
  output logic     overrun_o
);
  logic reject;
  logic room;

  assign reject = addr_det_i & nine_bit_i & ~char_i.bit9;
  assign room   = ~full_o | rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o     <= '0;
      full_o    <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (rd_i) full_o <= 1'b0;
      if (done_i && !reject) begin
        if (room) begin
          buf_o.data <= char_i.data;
          buf_o.bit9 <= nine_bit_i & char_i.bit9;
          buf_o.ferr <= char_i.ferr;
          full_o     <= 1'b1;
        end else begin
          overrun_o <= 1'b1;
        end
      end
      if (!rx_en_i) overrun_o <= 1'b0;
    end
  end

  AST_FILTER_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && reject && !rd_i) |=> full_o == $past(full_o)); // R7

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && rx_en_i) |=> overrun_o); // R10

  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !overrun_o); // R10

  AST_READY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(done_i)); // R5

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> $stable(buf_o)); // R9
endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rx_i,
  input  logic              port_en_i,
  input  logic              rx_en_i,
  input  logic              sync_mode_i,
  input  logic              nine_bit_i,
  input  logic              addr_det_i,
  input  logic              invert_i,
  input  logic              irq_en_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              frame_err_o,
  output logic              overrun_o,
  output logic              ready_o,
  output logic              irq_o
);
  logic     line;
  logic     rx_active;
  logic     done;
  rx_char_t shf_char;
  rx_char_t buf_char;

  assign rx_active = port_en_i & rx_en_i & ~sync_mode_i;

  rx_front #(.SYNC_STAGES(2)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_i),
    .invert_i (invert_i),
    .line_o   (line)
  );

  rx_shifter u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .line_i     (line),
    .en_i       (rx_active),
    .halt_i     (overrun_o),
    .nine_bit_i (nine_bit_i),
    .done_o     (done),
    .char_o     (shf_char)
  );

  rx_buffer u_buffer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .char_i     (shf_char),
    .nine_bit_i (nine_bit_i),
    .addr_det_i (addr_det_i),
    .rx_en_i    (rx_en_i),
    .rd_i       (rd_data_i),
    .buf_o      (buf_char),
    .full_o     (ready_o),
    .overrun_o  (overrun_o)
  );

  assign data_o      = buf_char.data;
  assign bit9_o      = buf_char.bit9;
  assign frame_err_o = buf_char.ferr;
  assign irq_o       = ready_o & irq_en_i;
endmodule

// File: tb/addr_uart_rx_tb_top.sv
module addr_uart_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rx = 1'b1;
  logic port_en = 1'b1, rx_en = 1'b1, sync_mode = 1'b0, nine_bit = 1'b0;
  logic addr_det = 1'b0, invert = 1'b0, irq_en = 1'b1;
  logic mon_rd = 1'b0, man_rd = 1'b0, auto_rd = 1'b1;
  logic rd;
  logic [7:0] data;
  logic bit9, ferr, ovr, ready, irq;
  int n_cmp = 0, n_bad = 0;
  logic [1:0] tcnt = '0;
  logic [9:0] exp_q[$];

  localparam int BIT_CLKS = 64;

  always #2 clk = ~clk;
  always_ff @(posedge clk) begin
    tcnt <= tcnt + 1'b1;
    tick <= (tcnt == 2'd3);
  end
  assign rd = mon_rd | man_rd;

  addr_uart_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx),
    .port_en_i(port_en), .rx_en_i(rx_en), .sync_mode_i(sync_mode),
    .nine_bit_i(nine_bit), .addr_det_i(addr_det), .invert_i(invert),
    .irq_en_i(irq_en), .rd_data_i(rd), .data_o(data), .bit9_o(bit9),
    .frame_err_o(ferr), .overrun_o(ovr), .ready_o(ready), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk);
    rx = b ^ invert;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stop_ok);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (nine_bit) drive_bit(b9);
    drive_bit(stop_ok);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  // driver: push expectation from the requirements, then send
  task automatic send_exp(input logic [7:0] d, input logic b9, input logic stop_ok);
    logic keep;
    keep = !(addr_det && nine_bit && !b9);
    if (keep) exp_q.push_back({d, nine_bit & b9, ~stop_ok});
    send(d, b9, stop_ok);
  endtask

  task automatic pop_manual();
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      mon_rd = 1'b0;
      if (rst_n && auto_rd && ready) begin
        logic [9:0] e;
        if (exp_q.size() == 0) begin
          check("R7 unexpected char", {data, bit9, ferr}, 0);
        end else begin
          e = exp_q.pop_front();
          check("R2 data", data, e[9:2]);
          check("R3 bit9", bit9, e[1]);
          check("R6 frame_err", ferr, e[0]);
          check("R5 irq", irq, irq_en);
        end
        mon_rd = 1'b1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R5 reset ready", ready, 0);
    check("R5 reset overrun", ovr, 0);
    check("R5 reset irq", irq, 0);
    check("R5 reset data", data, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2 8-bit, LSB first; R5 irq enabled
    send_exp(8'hA5, 1'b0, 1'b1);
    send_exp(8'h3C, 1'b0, 1'b1);
    irq_en = 1'b0;
    send_exp(8'h01, 1'b0, 1'b1);
    irq_en = 1'b1;

    // R3 9-bit
    nine_bit = 1'b1;
    send_exp(8'h5A, 1'b1, 1'b1);
    send_exp(8'hF0, 1'b0, 1'b1);

    // R6 framing error then clean character
    nine_bit = 1'b0;
    send_exp(8'h77, 1'b0, 1'b0);
    send_exp(8'h78, 1'b0, 1'b1);

    // R4 inverted line
    invert = 1'b1;
    @(negedge clk); rx = 1'b0;
    repeat (BIT_CLKS * 2) @(negedge clk);
    send_exp(8'hC3, 1'b0, 1'b1);
    send_exp(8'h81, 1'b0, 1'b1);
    invert = 1'b0;
    @(negedge clk); rx = 1'b1;
    repeat (BIT_CLKS * 2) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 0);

    // R7 address detect
    nine_bit = 1'b1; addr_det = 1'b1;
    send_exp(8'h12, 1'b0, 1'b1);
    check("R7 data char dropped", ready, 0);
    send_exp(8'h42, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    check("R7 address accepted", exp_q.size(), 0);
    // R8 filter off
    addr_det = 1'b0;
    send_exp(8'h9E, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check("R8 all accepted", exp_q.size(), 0);
    nine_bit = 1'b0;

    // R1 disabled paths
    port_en = 1'b0;
    send(8'h55, 1'b0, 1'b1);
    check("R1 port off", ready, 0);
    port_en = 1'b1; rx_en = 1'b0;
    send(8'h55, 1'b0, 1'b1);
    check("R1 rx off", ready, 0);
    rx_en = 1'b1; sync_mode = 1'b1;
    send(8'h55, 1'b0, 1'b1);
    check("R1 sync mode", ready, 0);
    sync_mode = 1'b0;

    // R11 false start
    @(negedge clk); rx = 1'b0;
    repeat (12) @(negedge clk);
    rx = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check("R11 glitch ignored", ready, 0);

    // R9 / R10 overrun
    auto_rd = 1'b0;
    send(8'h11, 1'b0, 1'b1);
    check("R9 first held", ready, 1);
    check("R9 no overrun yet", ovr, 0);
    send(8'h22, 1'b0, 1'b1);
    check("R9 overrun set", ovr, 1);
    check("R9 old data kept", data, 8'h11);
    pop_manual();
    check("R5 read clears ready", ready, 0);
    send(8'h33, 1'b0, 1'b1);
    check("R10 halted while overrun", ready, 0);
    check("R10 overrun sticky", ovr, 1);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 cleared by rx_en", ovr, 0);
    rx_en = 1'b1; auto_rd = 1'b1;
    repeat (3) @(negedge clk);
    send_exp(8'h44, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check("R10 resumes", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule